// File: doc/BRIEF.md
# Indirect-Addressed Host Register Interface

This block is the 8-bit slave port through which a host processor reaches a communications controller. The host uses an active-low select, separate active-low read and write strobes and a three-bit address. The block brings these asynchronous strobes into the system clock. It decodes eight direct locations: a command/interrupt location, a data port, two status bytes, a two-entry error queue and three channel buffer windows. It also drives an interrupt line.

Most configuration state lives in an indirect register bank. The host first writes a command byte that picks a start register and a group length. It then streams that many bytes through the single data port, and an internal pointer steps forward after every byte. A new command cancels any transfer still in progress. The channel buffers are plain byte FIFOs. Their far side is a simple push/pop line port that stands in for the channel datapaths.

Every access takes effect once, when its strobe is released. A strobe held low for a long time therefore cannot pop a queue twice or move the pointer twice.

Top module: `hostport_regif`

## Requirements
- R1: After reset, attn is low. A read of location 0 returns 0x00, location 2 returns 0x01, location 7 returns 0x11, and location 1 returns 0x00.
- R2: While sel_n is high, no strobe has any effect and bus_oe stays low.
- R3: Any bit pulsed high on irq_set latches into the interrupt byte, and attn rises. A read of location 0 returns the latched byte; releasing that read clears the byte and drops attn.
- R4: A write to location 0 is a command. Bits [4:0] give the start register and bits [7:6] give the group length (00=1, 01=2, 10=4, 11=8 bytes). Each write to location 1 stores into the current register and advances the pointer, which wraps from 31 to 0.
- R5: A read of location 1 returns the current register, and releasing the read advances the pointer within the group.
- R6: Once the group length is used up, writes to location 1 are ignored and reads return 0x00 until the next command.
- R7: A new command ends any transfer in progress, even one that has not used up its length.
- R8: A strobe during which read and write are both low has no effect.
- R9: A read strobe held low for many cycles acts only once.
- R10: Locations 4, 5 and 6 address the D, Bb and Bc channels. A write pushes into that channel's transmit FIFO, which the line side drains in order. A read pops that channel's receive FIFO, which the line side fills. Pushes into a full FIFO are dropped, and a read of an empty FIFO returns 0x00.
- R11: Location 3 pops a two-entry error queue fed by err_push. A third push into a full queue is dropped.
- R12: Location 2 reads {busy, 0, drx_full, err_full, err_nonempty, drx_nonempty, dtx_full, dtx_empty} (bit 7 first), where busy means group bytes remain. Location 7 reads {bc_rx_full, bc_rx_nonempty, bc_tx_full, bc_tx_empty, bb_rx_full, bb_rx_nonempty, bb_tx_full, bb_tx_empty}.
- R13: host_rst clears the command state, the register bank, every FIFO and the interrupt byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| host_rst | input | 1 | Asynchronous active-high reset |
| sel_n | input | 1 | Active-low select |
| rstb_n | input | 1 | Active-low read strobe |
| wstb_n | input | 1 | Active-low write strobe |
| adr | input | 3 | Direct location |
| bus_in | input | 8 | Write data from host |
| bus_out | output | 8 | Read data to host |
| bus_oe | output | 1 | High while read data is driven |
| attn | output | 1 | Interrupt to host |
| irq_set | input | 8 | Interrupt source pulses |
| err_push | input | 1 | Push error code |
| err_code | input | 8 | Error code |
| ln_tx_pop | input | 3 | Line-side pop per channel (D, Bb, Bc) |
| ln_tx_data | output | 24 | Transmit FIFO heads, D in [7:0] |
| ln_tx_valid | output | 3 | Transmit FIFO not empty |
| ln_rx_push | input | 3 | Line-side push per channel |
| ln_rx_data | input | 24 | Receive bytes, D in [7:0] |

## Verification
The bench builds the block with D-channel FIFOs of 8 entries and Bb/Bc FIFOs of 4 entries. At these sizes the full-queue drop on both buffer kinds can be reached in a few strobes. A 4-byte group that starts at register 30 exercises pointer wrap. The sizes also allow an 8-byte command to be aborted after two bytes. The bench drives overlapping strobes, strobes held for 40 cycles and strobes with select high, and checks for each that no state changed.

// File: rtl/hri_pkg.sv
package hri_pkg;
    typedef enum logic [2:0] {
        LOC_CTRL  = 3'd0,
        LOC_DATA  = 3'd1,
        LOC_STAT1 = 3'd2,
        LOC_ERRQ  = 3'd3,
        LOC_DCH   = 3'd4,
        LOC_BBCH  = 3'd5,
        LOC_BCCH  = 3'd6,
        LOC_STAT2 = 3'd7
    } hri_loc_e;

    localparam int NUM_CH   = 3;
    localparam int LEN_W    = 4;
    localparam int ERR_SLOTS = 2;

    function automatic logic [LEN_W-1:0] group_len(input logic [1:0] code);
        return LEN_W'(4'd1 << code);
    endfunction
endpackage

// File: rtl/hri_strobe_sync.sv
module hri_strobe_sync (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_n,
    input  logic       rstb_n,
    input  logic       wstb_n,
    input  logic [2:0] adr,
    input  logic [7:0] bus_in,
    output logic       rd_evt,
    output logic       wr_evt,
    output logic [2:0] ev_addr,
    output logic [7:0] ev_data,
    output logic       rd_live,
    output logic       rd_act,
    output logic       wr_act
);
    typedef struct packed {
        logic [1:0] sel_p;
        logic [1:0] rd_p;
        logic [1:0] wr_p;
        logic       rd_arm;
        logic       wr_arm;
        logic       bad;
        logic [2:0] addr;
        logic [7:0] data;
    } sync_t;

    sync_t q, d;
    logic sel_s, rd_s, wr_s;

    always_comb begin
        d      = q;
        sel_s  = q.sel_p[1];
        rd_s   = q.rd_p[1];
        wr_s   = q.wr_p[1];
        d.sel_p = {q.sel_p[0], ~sel_n};
        d.rd_p  = {q.rd_p[0], ~rstb_n};
        d.wr_p  = {q.wr_p[0], ~wstb_n};

        if (rd_s && wr_s)
            d.bad = 1'b1;
        else if (!rd_s && !wr_s)
            d.bad = 1'b0;

        if (rd_s && sel_s && !wr_s) begin
            d.rd_arm = 1'b1;
            d.addr   = adr;
        end
        if (wr_s && sel_s && !rd_s) begin
            d.wr_arm = 1'b1;
            d.addr   = adr;
            d.data   = bus_in;
        end
        if (!rd_s) d.rd_arm = 1'b0;
        if (!wr_s) d.wr_arm = 1'b0;

        rd_evt  = q.rd_arm && !rd_s && !wr_s && !q.bad;
        wr_evt  = q.wr_arm && !wr_s && !rd_s && !q.bad;
        rd_live = q.rd_arm && rd_s && !wr_s && sel_s && !q.bad;
        ev_addr = q.addr;
        ev_data = q.data;
        rd_act  = rd_s;
        wr_act  = wr_s;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/hri_byte_fifo.sv
module hri_byte_fifo #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] wdata,
    input  logic       pop,
    output logic [7:0] head,
    output logic       empty,
    output logic       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t q, d;
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        empty   = (q.cnt == '0);
        full    = (q.cnt == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp        = (q.wp == LAST) ? '0 : q.wp + 1'b1;
        end
        if (do_pop)
            d.rp = (q.rp == LAST) ? '0 : q.rp + 1'b1;
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        head  = empty ? 8'h00 : q.mem[q.rp];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/hri_indirect.sv
module hri_indirect
    import hri_pkg::*;
#(
    parameter int BANK_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic             dr_we,
    input  logic             dr_re,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [LEN_W-1:0] left
);
    localparam int AW = $clog2(BANK_BYTES);

    typedef struct packed {
        logic [BANK_BYTES-1:0][7:0] bank;
        logic [AW-1:0]              ptr;
        logic [LEN_W-1:0]           left;
    } ind_t;

    ind_t q, d;

    always_comb begin
        d = q;
        if (cmd_we) begin
            d.ptr  = wdata[AW-1:0];
            d.left = group_len(wdata[7:6]);
        end else if (q.left != '0 && (dr_we || dr_re)) begin
            if (dr_we)
                d.bank[q.ptr] = wdata;
            d.ptr  = q.ptr + 1'b1;
            d.left = q.left - 1'b1;
        end
        rdata = (q.left != '0) ? q.bank[q.ptr] : 8'h00;
        left  = q.left;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/hostport_regif.sv
module hostport_regif
    import hri_pkg::*;
#(
    parameter int D_TX_DEPTH = 8,
    parameter int D_RX_DEPTH = 8,
    parameter int B_DEPTH    = 4,
    parameter int BANK_BYTES = 32
) (
    input  logic                clk,
    input  logic                host_rst,
    input  logic                sel_n,
    input  logic                rstb_n,
    input  logic                wstb_n,
    input  logic [2:0]          adr,
    input  logic [7:0]          bus_in,
    output logic [7:0]          bus_out,
    output logic                bus_oe,
    output logic                attn,
    input  logic [7:0]          irq_set,
    input  logic                err_push,
    input  logic [7:0]          err_code,
    input  logic [NUM_CH-1:0]   ln_tx_pop,
    output logic [8*NUM_CH-1:0] ln_tx_data,
    output logic [NUM_CH-1:0]   ln_tx_valid,
    input  logic [NUM_CH-1:0]   ln_rx_push,
    input  logic [8*NUM_CH-1:0] ln_rx_data
);
    logic             rd_evt, wr_evt, rd_live, rd_act, wr_act;
    logic [2:0]       ev_addr;
    logic [7:0]       ev_data;
    logic [7:0]       ind_rdata;
    logic [LEN_W-1:0] ind_left;
    logic             cmd_we, dr_we, dr_re;
    logic [NUM_CH-1:0] tx_push, tx_empty, tx_full;
    logic [NUM_CH-1:0] rx_pop, rx_empty, rx_full;
    logic [7:0]       rx_head [NUM_CH];
    logic [7:0]       err_head;
    logic             err_empty, err_full, err_pop;
    logic [7:0]       stat1, stat2;

    typedef struct packed {
        logic [7:0] ir;
    } top_t;
    top_t q, d;

    hri_strobe_sync u_sync (
        .clk(clk), .rst(host_rst), .sel_n(sel_n), .rstb_n(rstb_n), .wstb_n(wstb_n),
        .adr(adr), .bus_in(bus_in), .rd_evt(rd_evt), .wr_evt(wr_evt),
        .ev_addr(ev_addr), .ev_data(ev_data), .rd_live(rd_live),
        .rd_act(rd_act), .wr_act(wr_act)
    );

    assign cmd_we = wr_evt && (ev_addr == LOC_CTRL);
    assign dr_we  = wr_evt && (ev_addr == LOC_DATA);
    assign dr_re  = rd_evt && (ev_addr == LOC_DATA);
    assign err_pop = rd_evt && (ev_addr == LOC_ERRQ);

    hri_indirect #(.BANK_BYTES(BANK_BYTES)) u_ind (
        .clk(clk), .rst(host_rst), .cmd_we(cmd_we), .dr_we(dr_we), .dr_re(dr_re),
        .wdata(ev_data), .rdata(ind_rdata), .left(ind_left)
    );

    hri_byte_fifo #(.DEPTH(ERR_SLOTS)) u_errq (
        .clk(clk), .rst(host_rst), .push(err_push), .wdata(err_code), .pop(err_pop),
        .head(err_head), .empty(err_empty), .full(err_full)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int TXD = (g == 0) ? D_TX_DEPTH : B_DEPTH;
        localparam int RXD = (g == 0) ? D_RX_DEPTH : B_DEPTH;
        localparam logic [2:0] LOC = 3'(LOC_DCH + g);

        assign tx_push[g] = wr_evt && (ev_addr == LOC);
        assign rx_pop[g]  = rd_evt && (ev_addr == LOC);

        hri_byte_fifo #(.DEPTH(TXD)) u_tx (
            .clk(clk), .rst(host_rst), .push(tx_push[g]), .wdata(ev_data),
            .pop(ln_tx_pop[g]), .head(ln_tx_data[8*g +: 8]),
            .empty(tx_empty[g]), .full(tx_full[g])
        );
        hri_byte_fifo #(.DEPTH(RXD)) u_rx (
            .clk(clk), .rst(host_rst), .push(ln_rx_push[g]), .wdata(ln_rx_data[8*g +: 8]),
            .pop(rx_pop[g]), .head(rx_head[g]),
            .empty(rx_empty[g]), .full(rx_full[g])
        );
        assign ln_tx_valid[g] = !tx_empty[g];
    end

    always_comb begin
        stat1 = {ind_left != '0, 1'b0, rx_full[0], err_full, !err_empty,
                 !rx_empty[0], tx_full[0], tx_empty[0]};
        stat2 = {rx_full[2], !rx_empty[2], tx_full[2], tx_empty[2],
                 rx_full[1], !rx_empty[1], tx_full[1], tx_empty[1]};
    end

    always_comb begin
        d = q;
        if (rd_evt && ev_addr == LOC_CTRL)
            d.ir = 8'h00;
        d.ir = d.ir | irq_set;
    end

    always_comb begin
        bus_out = 8'h00;
        if (rd_live) begin
            case (ev_addr)
                LOC_CTRL:  bus_out = q.ir;
                LOC_DATA:  bus_out = ind_rdata;
                LOC_STAT1: bus_out = stat1;
                LOC_ERRQ:  bus_out = err_head;
                LOC_DCH:   bus_out = rx_head[0];
                LOC_BBCH:  bus_out = rx_head[1];
                LOC_BCCH:  bus_out = rx_head[2];
                default:   bus_out = stat2;
            endcase
        end
        bus_oe = rd_live;
        attn   = (q.ir != 8'h00);
    end

    always_ff @(posedge clk or posedge host_rst) begin
        if (host_rst) q <= '0;
        else          q <= d;
    end
endmodule

// File: rtl/hostport_regif_chk.sv
module hostport_regif_chk (
    input logic       clk,
    input logic       host_rst,
    input logic       rd_evt,
    input logic       wr_evt,
    input logic [2:0] ev_addr,
    input logic [7:0] ev_data,
    input logic       rd_act,
    input logic       wr_act,
    input logic       attn,
    input logic [7:0] irq_set,
    input logic [3:0] ind_left
);
    p_one_action_r9: assert property (@(posedge clk) disable iff (host_rst)
        (rd_evt || wr_evt) |=> !(rd_evt || wr_evt));

    p_overlap_void_r8: assert property (@(posedge clk) disable iff (host_rst)
        (rd_act && wr_act) |=> !(rd_evt || wr_evt));

    p_ir_clear_r3: assert property (@(posedge clk) disable iff (host_rst)
        (rd_evt && ev_addr == 3'd0 && irq_set == 8'h00) |=> !attn);

    p_ir_latch_r3: assert property (@(posedge clk) disable iff (host_rst)
        (irq_set != 8'h00) |=> attn);

    p_cmd_restart_r7: assert property (@(posedge clk) disable iff (host_rst)
        (wr_evt && ev_addr == 3'd0) |=> ind_left == 4'(4'd1 << $past(ev_data[7:6])));

    p_exhausted_r6: assert property (@(posedge clk) disable iff (host_rst)
        (ind_left == 4'd0 && !(wr_evt && ev_addr == 3'd0)) |=> ind_left == 4'd0);

    p_step_r4: assert property (@(posedge clk) disable iff (host_rst)
        (ind_left != 4'd0 && (rd_evt || wr_evt) && ev_addr == 3'd1) |=> ind_left == $past(ind_left) - 4'd1);
endmodule

bind hostport_regif hostport_regif_chk u_chk (
    .clk(clk), .host_rst(host_rst), .rd_evt(rd_evt), .wr_evt(wr_evt),
    .ev_addr(ev_addr), .ev_data(ev_data), .rd_act(rd_act), .wr_act(wr_act),
    .attn(attn), .irq_set(irq_set), .ind_left(ind_left)
);

// File: tb/hostport_regif_test.sv
module hostport_regif_test;
    logic        clk = 1'b0;
    logic        host_rst = 1'b1;
    logic        sel_n = 1'b1, rstb_n = 1'b1, wstb_n = 1'b1;
    logic [2:0]  adr = 3'd0;
    logic [7:0]  bus_in = 8'h00;
    logic [7:0]  bus_out;
    logic        bus_oe, attn;
    logic [7:0]  irq_set = 8'h00;
    logic        err_push = 1'b0;
    logic [7:0]  err_code = 8'h00;
    logic [2:0]  ln_tx_pop = 3'b000;
    logic [23:0] ln_tx_data;
    logic [2:0]  ln_tx_valid;
    logic [2:0]  ln_rx_push = 3'b000;
    logic [23:0] ln_rx_data = 24'h0;
    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #5 clk = ~clk;

    hostport_regif #(.D_TX_DEPTH(8), .D_RX_DEPTH(8), .B_DEPTH(4), .BANK_BYTES(32)) uut (
        .clk(clk), .host_rst(host_rst), .sel_n(sel_n), .rstb_n(rstb_n), .wstb_n(wstb_n),
        .adr(adr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .attn(attn),
        .irq_set(irq_set), .err_push(err_push), .err_code(err_code),
        .ln_tx_pop(ln_tx_pop), .ln_tx_data(ln_tx_data), .ln_tx_valid(ln_tx_valid),
        .ln_rx_push(ln_rx_push), .ln_rx_data(ln_rx_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); adr = a; bus_in = v; sel_n = 1'b0; wstb_n = 1'b0;
        repeat (6) @(negedge clk);
        wstb_n = 1'b1;
        @(negedge clk); sel_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic host_rd(input logic [2:0] a, input int hold, output logic [7:0] v);
        @(negedge clk); adr = a; sel_n = 1'b0; rstb_n = 1'b0;
        repeat (hold) @(negedge clk);
        v = bus_out;
        rstb_n = 1'b1;
        @(negedge clk); sel_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk); host_rst = 1'b1;
        repeat (3) @(negedge clk); host_rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state;
        check("R1 attn", {7'd0, attn}, 8'h00);
        host_rd(3'd0, 6, rv); check("R1 ir", rv, 8'h00);
        host_rd(3'd2, 6, rv); check("R1 stat1", rv, 8'h01);
        host_rd(3'd7, 6, rv); check("R1 stat2", rv, 8'h11);
        host_rd(3'd1, 6, rv); check("R1 data idle", rv, 8'h00);
    endtask

    task automatic t_sel_high;
        @(negedge clk); adr = 3'd4; bus_in = 8'h77; wstb_n = 1'b0;
        repeat (6) @(negedge clk); wstb_n = 1'b1; repeat (6) @(negedge clk);
        check("R2 no push", {5'd0, ln_tx_valid}, 8'h00);
        adr = 3'd2; rstb_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R2 no drive", {7'd0, bus_oe}, 8'h00);
        rstb_n = 1'b1; repeat (6) @(negedge clk);
    endtask

    task automatic t_irq;
        @(negedge clk); irq_set = 8'h05; @(negedge clk); irq_set = 8'h00;
        check("R3 attn up", {7'd0, attn}, 8'h01);
        host_rd(3'd0, 6, rv); check("R3 ir value", rv, 8'h05);
        check("R3 attn down", {7'd0, attn}, 8'h00);
        host_rd(3'd0, 6, rv); check("R3 ir cleared", rv, 8'h00);
    endtask

    task automatic t_group_wrap;
        host_wr(3'd0, 8'h9E);
        host_wr(3'd1, 8'hA0); host_wr(3'd1, 8'hB1);
        host_wr(3'd1, 8'hC2); host_wr(3'd1, 8'hD3);
        host_wr(3'd0, 8'h9E);
        host_rd(3'd1, 6, rv); check("R5 reg30", rv, 8'hA0);
        host_rd(3'd1, 6, rv); check("R5 reg31", rv, 8'hB1);
        host_rd(3'd1, 6, rv); check("R4 wrap reg0", rv, 8'hC2);
        host_rd(3'd1, 6, rv); check("R4 reg1", rv, 8'hD3);
        host_rd(3'd1, 6, rv); check("R6 read past end", rv, 8'h00);
        host_wr(3'd1, 8'hEE);
        host_wr(3'd0, 8'h02);
        host_rd(3'd1, 6, rv); check("R6 write past end ignored", rv, 8'h00);
        host_wr(3'd0, 8'h00);
        host_rd(3'd1, 6, rv); check("R4 len1 reg0", rv, 8'hC2);
    endtask

    task automatic t_abort;
        host_wr(3'd0, 8'hC8);
        host_wr(3'd1, 8'h11); host_wr(3'd1, 8'h22);
        host_wr(3'd0, 8'h4A);
        host_wr(3'd1, 8'h33);
        host_wr(3'd0, 8'hC8);
        host_rd(3'd1, 6, rv); check("R7 reg8", rv, 8'h11);
        host_rd(3'd1, 6, rv); check("R7 reg9", rv, 8'h22);
        host_rd(3'd1, 6, rv); check("R7 reg10 new cmd", rv, 8'h33);
        host_rd(3'd1, 6, rv); check("R7 reg11", rv, 8'h00);
    endtask

    task automatic t_overlap;
        host_wr(3'd0, 8'h0C);
        @(negedge clk); adr = 3'd1; bus_in = 8'h55; sel_n = 1'b0; wstb_n = 1'b0; rstb_n = 1'b0;
        repeat (6) @(negedge clk); wstb_n = 1'b1; rstb_n = 1'b1;
        @(negedge clk); sel_n = 1'b1; repeat (6) @(negedge clk);
        host_wr(3'd1, 8'h66);
        host_wr(3'd0, 8'h0C);
        host_rd(3'd1, 6, rv); check("R8 overlap no effect", rv, 8'h66);
        @(negedge clk); adr = 3'd4; bus_in = 8'h99; sel_n = 1'b0; rstb_n = 1'b0; wstb_n = 1'b0;
        repeat (6) @(negedge clk); rstb_n = 1'b1; wstb_n = 1'b1;
        @(negedge clk); sel_n = 1'b1; repeat (6) @(negedge clk);
        check("R8 no tx push", {5'd0, ln_tx_valid}, 8'h00);
    endtask

    task automatic t_long_strobe;
        @(negedge clk); ln_rx_data[15:8] = 8'h41; ln_rx_push = 3'b010;
        @(negedge clk); ln_rx_data[15:8] = 8'h42;
        @(negedge clk); ln_rx_push = 3'b000;
        host_rd(3'd5, 40, rv); check("R9 long read first", rv, 8'h41);
        host_rd(3'd5, 6, rv);  check("R9 single pop", rv, 8'h42);
        host_rd(3'd5, 6, rv);  check("R10 empty rx", rv, 8'h00);
    endtask

    task automatic t_fifos;
        for (int i = 0; i < 9; i++) host_wr(3'd4, 8'h10 + 8'(i));
        host_rd(3'd2, 6, rv); check("R12 dtx full", rv, 8'h02);
        for (int i = 0; i < 8; i++) begin
            check("R10 d tx order", ln_tx_data[7:0], 8'h10 + 8'(i));
            @(negedge clk); ln_tx_pop = 3'b001; @(negedge clk); ln_tx_pop = 3'b000;
        end
        check("R10 ninth dropped", {5'd0, ln_tx_valid}, 8'h00);
        host_wr(3'd6, 8'h5C);
        check("R10 bc tx head", ln_tx_data[23:16], 8'h5C);
        @(negedge clk); ln_tx_pop = 3'b100; @(negedge clk); ln_tx_pop = 3'b000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ln_rx_data[7:0] = 8'h70 + 8'(i); ln_rx_push = 3'b001;
        end
        @(negedge clk); ln_rx_push = 3'b000;
        for (int i = 0; i < 3; i++) begin
            host_rd(3'd4, 6, rv); check("R10 d rx order", rv, 8'h70 + 8'(i));
        end
    endtask

    task automatic t_errq;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); err_code = 8'hA1 + 8'(i); err_push = 1'b1;
        end
        @(negedge clk); err_push = 1'b0;
        host_rd(3'd2, 6, rv); check("R12 err bits", rv, 8'h19);
        host_rd(3'd3, 6, rv); check("R11 err first", rv, 8'hA1);
        host_rd(3'd3, 6, rv); check("R11 err second", rv, 8'hA2);
        host_rd(3'd3, 6, rv); check("R11 third dropped", rv, 8'h00);
    endtask

    task automatic t_status;
        host_wr(3'd0, 8'h00); host_rd(3'd1, 6, rv);
        for (int i = 0; i < 4; i++) host_wr(3'd5, 8'h20 + 8'(i));
        host_rd(3'd7, 6, rv); check("R12 bb tx full", rv, 8'h12);
        @(negedge clk); ln_rx_data[23:16] = 8'h3C; ln_rx_push = 3'b100;
        @(negedge clk); ln_rx_push = 3'b000;
        host_rd(3'd7, 6, rv); check("R12 bc rx nonempty", rv, 8'h52);
        host_wr(3'd0, 8'h40);
        host_rd(3'd2, 6, rv); check("R12 busy", rv, 8'h81);
    endtask

    task automatic t_reset_clears;
        @(negedge clk); irq_set = 8'h80; @(negedge clk); irq_set = 8'h00;
        do_reset();
        check("R13 attn", {7'd0, attn}, 8'h00);
        check("R13 tx empty", {5'd0, ln_tx_valid}, 8'h00);
        host_rd(3'd2, 6, rv); check("R13 stat1", rv, 8'h01);
        host_rd(3'd7, 6, rv); check("R13 stat2", rv, 8'h11);
        host_wr(3'd0, 8'h0A);
        host_rd(3'd1, 6, rv); check("R13 bank cleared", rv, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        host_rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_sel_high();
        t_irq();
        t_group_wrap();
        t_abort();
        t_overlap();
        t_long_strobe();
        t_fifos();
        t_errq();
        t_status();
        t_reset_clears();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule